// File: doc/BRIEF.md
# Shift-Loop Odd-Ratio Clock Divider

This block divides its input clock by an odd ratio of 3, 5, 7 or 13, fixed at elaboration time. The state is held in a short chain of D registers. The chain works as a shift register: only the head register gets a combinational next-state bit, and each later register copies its upstream neighbour on every rising edge. The encodings are chosen so that shifting the chain with the right head bit walks a closed cycle of exactly N codes. The all-zero code is one of them, and a synchronous reset loads it.

A second parameter selects the output shape. In tap mode the divided clock is a registered decode of the state, so it changes only on rising input edges. In half-extension mode a falling-edge register samples that decode, and the output is the OR of the two. This stretches the high phase by half an input period and gives an exact 50% duty cycle at an odd ratio. The state vector is also an output, so a neighbour can take phase information from it. Bit W-1 of the state vector is the head register. Bit 0 is the last register in the chain.

Top module: `odd_shift_divider`

## Requirements
- R1: While `sync_rst` is high on a rising edge, `div_state` becomes all zero after that edge, and `clk_div` is low once a full input cycle of reset has passed.
- R2: On every rising edge outside reset, bit k of `div_state` takes the previous value of bit k+1, for every k below W-1.
- R3: Outside reset, `div_state` holds only codes of the selected cycle, and it visits the all-zero code exactly once every N rising edges.
- R4: For N=3 (W=2), starting from 00 after reset, the state follows 00, 10, 01 and repeats. Written MSB first, these are the values 0, 2, 1.
- R5: For N=5 (W=3), the state follows 000, 100, 110, 011, 001 and repeats. These are the values 0, 4, 6, 3, 1.
- R6: For N=7 (W=3), the state follows the values 0, 4, 2, 5, 6, 3, 1 and repeats.
- R7: For N=13 (W=4), the state follows the values 0, 8, 4, 10, 5, 2, 9, 12, 14, 15, 7, 3, 1 and repeats.
- R8: In both modes, `clk_div` is periodic with a period of exactly N input cycles.
- R9: In tap mode, `clk_div` is high for the last H states of the cycle, with H = 2, 2, 3, 6 for N = 3, 5, 7, 13. It rises and falls only on rising input edges.
- R10: In half-extension mode, `clk_div` is high for (N-1)/2 input cycles plus one half cycle. It rises on a rising edge at the start of state index (N+1)/2 and falls on the falling edge inside state index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| sync_rst | input | 1 | Synchronous reset, active high, loads the all-zero code |
| clk_div | output | 1 | Divided clock |
| div_state | output | W | Chain contents; bit W-1 is the head register |

## Verification
A state step shows on `div_state` one rising edge after the edge that causes it. The tap-mode output comes from a register fed by the next-state decode, so it lines up with the state of the same cycle. The half-extension copy follows half a period later, at the falling edge. For these reasons the bench samples 2 ns after each rising edge and 2 ns after each falling edge. It records one value per half period and counts high halves against 2H or 2H+1, with rise and fall positions given in half-period indices. Reset is checked two rising edges after it is raised, by which time the falling-edge register has also been cleared.

// File: rtl/odd_shift_divider_pkg.sv
package odd_shift_divider_pkg;

  localparam int MAX_W = 4;
  localparam int MAX_N = 13;

  typedef logic [MAX_W-1:0] code_t;

  typedef enum logic {
    DUTY_TAP  = 1'b0,
    DUTY_HALF = 1'b1
  } duty_mode_e;

  // Number of chain registers needed for a ratio.
  function automatic int state_width(int div);
    case (div)
      3:       return 2;
      13:      return 4;
      default: return 3;
    endcase
  endfunction

  // Head feedback bit for a code; the head is bit W-1.
  function automatic logic head_bit(int div, code_t s);
    logic ra, rb, rc, rd;
    ra = 1'b0; rb = 1'b0; rc = 1'b0; rd = 1'b0;
    case (div)
      3: begin
        ra = s[1]; rb = s[0];
        return ~(ra | rb);
      end
      5: begin
        rb = s[1]; rc = s[0];
        return ~(rb | rc);
      end
      7: begin
        ra = s[2]; rc = s[0];
        return ~(ra ^ rc);
      end
      default: begin
        ra = s[3]; rb = s[2]; rc = s[1]; rd = s[0];
        return ~(ra | rd | (rb & rc)) | (ra & (rb ^ rd));
      end
    endcase
  endfunction

  // One shift step of the loop.
  function automatic code_t shift_code(int div, code_t s);
    int w;
    w = state_width(div);
    return code_t'((s >> 1) | (code_t'(head_bit(div, s)) << (w - 1)));
  endfunction

  // Position of a code in the cycle that starts at zero; div if absent.
  function automatic int code_index(int div, code_t s);
    code_t c;
    c = '0;
    for (int k = 0; k < MAX_N; k++) begin
      if (k < div && c == s) return k;
      c = shift_code(div, c);
    end
    return div;
  endfunction

  // Whole input cycles per period where the registered tap is high.
  function automatic int high_states(int div, logic half);
    if (half) return (div - 1) / 2;
    case (div)
      3:       return 2;
      5:       return 2;
      7:       return 3;
      default: return 6;
    endcase
  endfunction

  // Tap level for a code: high in the last 'high' codes of the cycle.
  function automatic logic tap_level(int div, int high, code_t s);
    int idx;
    idx = code_index(div, s);
    return (idx >= div - high) && (idx < div);
  endfunction

endpackage

// File: rtl/osd_head_logic.sv
module osd_head_logic
  import odd_shift_divider_pkg::*;
#(
  parameter int DIV = 5,
  parameter int W   = 3
) (
  input  logic [W-1:0] cur_state,
  output logic         head_d
);

  if (DIV == 3) begin : g_div3
    assign head_d = ~(cur_state[1] | cur_state[0]);
  end else if (DIV == 5) begin : g_div5
    assign head_d = ~(cur_state[1] | cur_state[0]);
  end else if (DIV == 7) begin : g_div7
    assign head_d = ~(cur_state[2] ^ cur_state[0]);
  end else begin : g_div13
    logic r_a, r_b, r_c, r_d;
    assign r_a = cur_state[3];
    assign r_b = cur_state[2];
    assign r_c = cur_state[1];
    assign r_d = cur_state[0];
    assign head_d = ~(r_a | r_d | (r_b & r_c)) | (r_a & (r_b ^ r_d));
  end

endmodule

// File: rtl/osd_shift_chain.sv
module osd_shift_chain #(
  parameter int W = 3
) (
  input  logic         clk_in,
  input  logic         sync_rst,
  input  logic         head_d,
  output logic [W-1:0] q
);

  for (genvar g = W - 1; g >= 0; g--) begin : g_stage
    if (g == W - 1) begin : g_head
      always_ff @(posedge clk_in) begin
        if (sync_rst) q[g] <= 1'b0;
        else          q[g] <= head_d;
      end
    end else begin : g_copy
      always_ff @(posedge clk_in) begin
        if (sync_rst) q[g] <= 1'b0;
        else          q[g] <= q[g+1];
      end
    end
  end

endmodule

// File: rtl/osd_duty_stage.sv
module osd_duty_stage
  import odd_shift_divider_pkg::*;
#(
  parameter int         DIV  = 5,
  parameter duty_mode_e DUTY = DUTY_HALF,
  parameter int         W    = 3
) (
  input  logic         clk_in,
  input  logic         sync_rst,
  input  logic [W-1:0] next_state,
  output logic         tap_q,
  output logic         fall_q,
  output logic         clk_div
);

  localparam int HIGH = high_states(DIV, DUTY == DUTY_HALF);

  logic tap_d;
  assign tap_d = tap_level(DIV, HIGH, code_t'(next_state));

  always_ff @(posedge clk_in) begin
    if (sync_rst) tap_q <= 1'b0;
    else          tap_q <= tap_d;
  end

  if (DUTY == DUTY_HALF) begin : g_half
    always_ff @(negedge clk_in) begin
      if (sync_rst) fall_q <= 1'b0;
      else          fall_q <= tap_q;
    end
    assign clk_div = tap_q | fall_q;
  end else begin : g_tap
    assign fall_q  = 1'b0;
    assign clk_div = tap_q;
  end

endmodule

// File: rtl/odd_shift_divider.sv
module odd_shift_divider
  import odd_shift_divider_pkg::*;
#(
  parameter int         DIV  = 5,
  parameter duty_mode_e DUTY = DUTY_HALF,
  localparam int        W    = state_width(DIV)
) (
  input  logic         clk_in,
  input  logic         sync_rst,
  output logic         clk_div,
  output logic [W-1:0] div_state
);

  logic         head_d;
  logic [W-1:0] next_state;
  logic         tap_q;
  logic         fall_q;

  osd_head_logic #(.DIV(DIV), .W(W)) u_head (
    .cur_state (div_state),
    .head_d    (head_d)
  );

  osd_shift_chain #(.W(W)) u_chain (
    .clk_in   (clk_in),
    .sync_rst (sync_rst),
    .head_d   (head_d),
    .q        (div_state)
  );

  assign next_state = {head_d, div_state[W-1:1]};

  osd_duty_stage #(.DIV(DIV), .DUTY(DUTY), .W(W)) u_duty (
    .clk_in     (clk_in),
    .sync_rst   (sync_rst),
    .next_state (next_state),
    .tap_q      (tap_q),
    .fall_q     (fall_q),
    .clk_div    (clk_div)
  );

endmodule

// File: rtl/osd_checker.sv
module osd_checker
  import odd_shift_divider_pkg::*;
#(
  parameter int         DIV  = 5,
  parameter duty_mode_e DUTY = DUTY_HALF,
  parameter int         W    = 3
) (
  input logic         clk_in,
  input logic         sync_rst,
  input logic [W-1:0] div_state,
  input logic         tap_q,
  input logic         fall_q,
  input logic         clk_div
);

  localparam int HIGH = high_states(DIV, DUTY == DUTY_HALF);

  logic       seen_rst = 1'b0;
  logic       prev_rst = 1'b0;
  logic       zero_seen;
  logic [4:0] since_zero;
  logic [4:0] high_cnt;
  logic       live;

  always_ff @(posedge clk_in) begin
    seen_rst <= seen_rst | sync_rst;
    prev_rst <= sync_rst;
  end

  assign live = seen_rst && !prev_rst;

  always_ff @(posedge clk_in) begin
    if (sync_rst) begin
      zero_seen  <= 1'b0;
      since_zero <= '0;
      high_cnt   <= '0;
    end else if (div_state == '0) begin
      zero_seen  <= 1'b1;
      since_zero <= 5'd1;
      high_cnt   <= {4'b0, clk_div};
    end else begin
      since_zero <= since_zero + 5'd1;
      high_cnt   <= high_cnt + {4'b0, clk_div};
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk_in) disable iff (sync_rst)
    $past(sync_rst) |-> (div_state == '0 && tap_q == 1'b0)); // R1

  AST_CHAIN_SHIFT: assert property (@(posedge clk_in) disable iff (sync_rst || !live)
    div_state[W-2:0] == $past(div_state[W-1:1])); // R2

  AST_CODE_MEMBER: assert property (@(posedge clk_in) disable iff (sync_rst || !live)
    code_index(DIV, code_t'(div_state)) < DIV); // R3

  AST_CYCLE_LEN: assert property (@(posedge clk_in) disable iff (sync_rst || !live)
    (div_state == '0 && zero_seen) |-> since_zero == 5'(DIV)); // R8

  if (DUTY == DUTY_HALF) begin : g_half_chk
    AST_HALF_TRACK: assert property (@(posedge clk_in) disable iff (sync_rst || !live)
      fall_q == tap_q); // R10
    AST_HALF_HIGH: assert property (@(posedge clk_in) disable iff (sync_rst || !live)
      (div_state == '0 && zero_seen) |-> high_cnt == 5'(HIGH)); // R10
  end else begin : g_tap_chk
    AST_TAP_HIGH: assert property (@(posedge clk_in) disable iff (sync_rst || !live)
      (div_state == '0 && zero_seen) |-> high_cnt == 5'(HIGH)); // R9
    AST_TAP_NO_FALL: assert property (@(posedge clk_in) disable iff (sync_rst || !live)
      fall_q == 1'b0); // R9
  end

endmodule

bind odd_shift_divider osd_checker #(.DIV(DIV), .DUTY(DUTY), .W(W)) u_chk (
  .clk_in    (clk_in),
  .sync_rst  (sync_rst),
  .div_state (div_state),
  .tap_q     (tap_q),
  .fall_q    (fall_q),
  .clk_div   (clk_div)
);

// File: tb/odd_shift_divider_tb.sv
module odd_shift_divider_tb;
  import odd_shift_divider_pkg::*;

  localparam int NCFG  = 8;
  localparam int NEDGE = 120;
  localparam int NHALF = 2 * NEDGE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  logic [3:0] st [NCFG];
  logic       ck [NCFG];
  logic       smp [NCFG][NHALF];

  always #4 clk = ~clk;

  function automatic int cfg_div(int i);
    case (i % 4)
      0:       return 3;
      1:       return 5;
      2:       return 7;
      default: return 13;
    endcase
  endfunction

  function automatic bit cfg_half(int i);
    return i >= 4;
  endfunction

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    localparam int         D = cfg_div(i);
    localparam duty_mode_e M = cfg_half(i) ? DUTY_HALF : DUTY_TAP;
    logic [state_width(D)-1:0] st_raw;
    odd_shift_divider #(.DIV(D), .DUTY(M)) u_dut (
      .clk_in    (clk),
      .sync_rst  (rst),
      .clk_div   (ck[i]),
      .div_state (st_raw)
    );
    assign st[i] = 4'(st_raw);
  end

  function automatic logic [3:0] exp_code(int div, int k);
    case (div)
      3: case (k) 0: return 0; 1: return 2; default: return 1; endcase
      5: case (k) 0: return 0; 1: return 4; 2: return 6; 3: return 3; default: return 1; endcase
      7: case (k) 0: return 0; 1: return 4; 2: return 2; 3: return 5; 4: return 6; 5: return 3;
                 default: return 1; endcase
      default: case (k)
        0: return 0;  1: return 8;  2: return 4;  3: return 10; 4: return 5;
        5: return 2;  6: return 9;  7: return 12; 8: return 14; 9: return 15;
        10: return 7; 11: return 3; default: return 1;
      endcase
    endcase
  endfunction

  function automatic string seq_req(int div);
    case (div)
      3: return "R4";
      5: return "R5";
      7: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Whole cycles of high output per period for the tap decode.
  function automatic int exp_high(int div, bit half);
    if (half) return (div - 1) / 2;
    if (div == 13) return 6;
    if (div == 7) return 3;
    return 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    for (int i = 0; i < NCFG; i++) begin
      check(st[i] == 4'd0, "R1 state", int'(st[i]), 0);
      check(ck[i] == 1'b0, "R1 clk_div", int'(ck[i]), 0);
    end
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic t_sequence();
    logic [3:0] prev [NCFG];
    apply_reset();
    for (int i = 0; i < NCFG; i++) prev[i] = 4'd0;
    for (int k = 1; k <= 26; k++) begin
      @(posedge clk);
      #2;
      for (int i = 0; i < NCFG; i++) begin
        int d = cfg_div(i);
        int w = state_width(d);
        logic [3:0] e = exp_code(d, k % d);
        logic [3:0] low_mask = 4'((1 << (w - 1)) - 1);
        check(st[i] == e, seq_req(d), int'(st[i]), int'(e));
        check((st[i] & low_mask) == (prev[i] >> 1), "R2",
              int'(st[i] & low_mask), int'(prev[i] >> 1));
        check((st[i] == 4'd0) == ((k % d) == 0), "R3",
              int'(st[i] == 4'd0), int'((k % d) == 0));
        prev[i] = st[i];
      end
    end
  endtask

  task automatic t_duty();
    apply_reset();
    for (int e = 1; e <= NEDGE; e++) begin
      @(posedge clk);
      #2;
      for (int i = 0; i < NCFG; i++) smp[i][2*(e-1)] = ck[i];
      @(negedge clk);
      #2;
      for (int i = 0; i < NCFG; i++) smp[i][2*(e-1)+1] = ck[i];
    end
    for (int i = 0; i < NCFG; i++) begin
      int    n    = cfg_div(i);
      bit    half = cfg_half(i);
      int    h    = exp_high(n, half);
      int    b    = 4 * n - 2;
      int    r    = 2 * (n - h);
      int    cnt  = 0;
      int    want = half ? 2 * h + 1 : 2 * h;
      string dreq = half ? "R10" : "R9";
      for (int j = 0; j < 2 * n; j++) cnt += int'(smp[i][b + j]);
      check(cnt == want, dreq, cnt, want);
      check(smp[i][b + r - 1] == 1'b0 && smp[i][b + r] == 1'b1, dreq,
            int'(smp[i][b + r]), 1);
      check(smp[i][b + 2*n + r - 1] == 1'b0 && smp[i][b + 2*n + r] == 1'b1, "R8",
            int'(smp[i][b + 2*n + r]), 1);
      if (half)
        check(smp[i][b + 2*n] == 1'b1 && smp[i][b + 2*n + 1] == 1'b0, "R10",
              int'(smp[i][b + 2*n + 1]), 0);
      else
        check(smp[i][b + 2*n - 1] == 1'b1 && smp[i][b + 2*n] == 1'b0, "R9",
              int'(smp[i][b + 2*n]), 0);
    end
  endtask

  task automatic t_reset_midrun();
    repeat (7) @(posedge clk);
    t_reset();
    @(posedge clk);
    #2;
    for (int i = 0; i < NCFG; i++) begin
      int d = cfg_div(i);
      check(st[i] == exp_code(d, 1), "R1 restart", int'(st[i]), int'(exp_code(d, 1)));
    end
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_duty();
    t_reset_midrun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule